// File: doc/BRIEF.md
# Reloadable Up/Down Line Address Counter

This block produces the address for one port of a line-buffer memory, so a design with separate read and write ports uses two copies. On each rising clock edge the counter can hold, step up by one, step down by one, or restart. A restart is requested with an active-low reload strobe. The mode bit chooses the restart target: either a value supplied on a reload bus, or a fixed start value that depends on the count direction.

The counter is 16 bits wide. The low 13 bits index the array. The top 3 bits select a bank for depth expansion: they are compared with an expansion ID, and the port is active only while they are equal. The counter keeps stepping even while the bank does not match, so several buffers can share one address sequence. A sticky flag records every downward wrap through zero. A separate active-low strobe clears the flag.

All three outputs are registered and change together, one edge after the inputs that cause the change.

Top module: `lbc_addr_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the counter is set to 0x0000 and `wrap_flag` to 0. After that edge, `bank_hit` shows whether `exp_id` was 3'b000 at that edge.
- R2: When `reload_n`=1, `step_en`=1 and `dir_down`=0, the count rises by one at the edge. 0xFFFF is followed by 0x0000.
- R3: When `reload_n`=1, `step_en`=1 and `dir_down`=1, the count falls by one at the edge. 0x0000 is followed by 0xFFFF.
- R4: When `reload_n`=1 and `step_en`=0, the count does not change.
- R5: When `reload_n`=0 and `mode_load`=1, the count takes `reload_val`. This happens whatever the level of `step_en`, and the reload wins over any step.
- R6: When `reload_n`=0 and `mode_load`=0, the count is cleared and `reload_val` is ignored. The clear value is 0x0000 if `dir_down`=0 and 0xFFFF if `dir_down`=1, using the `dir_down` value sampled at that same edge. A reload right after a direction change therefore starts from the new direction's start value.
- R7: `wrap_flag` becomes 1 one edge after a downward step taken from 0x0000.
- R8: Once set, `wrap_flag` stays 1 until `flag_clr_n` is sampled 0 at an edge. An upward wrap from 0xFFFF to 0x0000 never sets it.
- R9: If a downward wrap and `flag_clr_n`=0 occur at the same edge, `wrap_flag` is 1 afterwards.
- R10: `bank_hit` is 1 exactly when bits [15:13] of the count equal the `exp_id` sampled at the same edge. It changes in the same cycle as the count. The count keeps stepping while `bank_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Active-high step request |
| reload_n | input | 1 | Active-low restart strobe |
| flag_clr_n | input | 1 | Active-low clear for the wrap flag |
| dir_down | input | 1 | Count direction: 0 up, 1 down |
| mode_load | input | 1 | Restart target: 1 takes `reload_val`, 0 clears |
| reload_val | input | 16 | Value taken on a loading restart |
| exp_id | input | 3 | Bank identifier compared with the top count bits |
| addr | output | 16 | Current count |
| bank_hit | output | 1 | Top count bits equal `exp_id` |
| wrap_flag | output | 1 | Sticky downward-wrap flag |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it. This holds for the new count, the flag set or clear, and the bank compare. No result takes longer.

The bench applies one set of inputs per cycle at the falling edge. It advances its reference count and flag with the same stimulus at that point. It then compares all three outputs at the next falling edge, so each check falls half a period after the single edge that produced the result. The bound checker states the same one-edge relations with `|=>` and `$past`.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_INC   = 3'd1,
    OP_DEC   = 3'd2,
    OP_LOAD  = 3'd3,
    OP_CLEAR = 3'd4
  } ctr_op_e;

endpackage

// File: rtl/lbc_op_decode.sv
module lbc_op_decode
  import lbc_pkg::*;
(
  input  logic    step_en,
  input  logic    reload_n,
  input  logic    dir_down,
  input  logic    mode_load,
  output ctr_op_e op
);

  // Restart first, then step, then hold.
  always_comb begin
    if (!reload_n)     op = mode_load ? OP_LOAD : OP_CLEAR;
    else if (step_en)  op = dir_down  ? OP_DEC  : OP_INC;
    else               op = OP_HOLD;
  end

endmodule

// File: rtl/lbc_next_addr.sv
module lbc_next_addr
  import lbc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  ctr_op_e           op,
  input  logic              dir_down,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [ADDR_W-1:0] reload_val,
  output logic [ADDR_W-1:0] addr_d,
  output logic              wrap_dn
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] start_val;

  // The clear target follows the direction sampled at the same edge.
  assign start_val = dir_down ? {ADDR_W{1'b1}} : {ADDR_W{1'b0}};

  always_comb begin
    unique case (op)
      OP_LOAD:  addr_d = reload_val;
      OP_CLEAR: addr_d = start_val;
      OP_INC:   addr_d = addr_q + ONE;
      OP_DEC:   addr_d = addr_q - ONE;
      default:  addr_d = addr_q;
    endcase
  end

  assign wrap_dn = (op == OP_DEC) && (addr_q == '0);

endmodule

// File: rtl/lbc_wrap_flag.sv
module lbc_wrap_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_n,
  output logic flag_q
);

  // A new wrap overrides a clear at the same edge.
  always_ff @(posedge clk) begin
    if (rst)         flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (!clr_n) flag_q <= 1'b0;
  end

endmodule

// File: rtl/lbc_bank_match.sv
module lbc_bank_match #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic [EXP_W-1:0] top_d,
  input  logic [EXP_W-1:0] exp_id,
  output logic             hit_q
);

  // Registered against the next count, so it changes together with addr.
  always_ff @(posedge clk) begin
    hit_q <= (top_d == exp_id);
  end

endmodule

// File: rtl/lbc_addr_counter.sv
module lbc_addr_counter
  import lbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int EXP_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic              reload_n,
  input  logic              flag_clr_n,
  input  logic              dir_down,
  input  logic              mode_load,
  input  logic [ADDR_W-1:0] reload_val,
  input  logic [EXP_W-1:0]  exp_id,
  output logic [ADDR_W-1:0] addr,
  output logic              bank_hit,
  output logic              wrap_flag
);

  localparam int TOP_LSB = ADDR_W - EXP_W;

  ctr_op_e           op;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic [ADDR_W-1:0] addr_eff;
  logic              wrap_dn;

  lbc_op_decode u_dec (
    .step_en   (step_en),
    .reload_n  (reload_n),
    .dir_down  (dir_down),
    .mode_load (mode_load),
    .op        (op)
  );

  lbc_next_addr #(.ADDR_W(ADDR_W)) u_nxt (
    .op         (op),
    .dir_down   (dir_down),
    .addr_q     (addr_q),
    .reload_val (reload_val),
    .addr_d     (addr_d),
    .wrap_dn    (wrap_dn)
  );

  assign addr_eff = rst ? '0 : addr_d;

  always_ff @(posedge clk) begin
    addr_q <= addr_eff;
  end

  lbc_wrap_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (wrap_dn),
    .clr_n  (flag_clr_n),
    .flag_q (wrap_flag)
  );

  lbc_bank_match #(.EXP_W(EXP_W)) u_bank (
    .clk    (clk),
    .top_d  (addr_eff[ADDR_W-1:TOP_LSB]),
    .exp_id (exp_id),
    .hit_q  (bank_hit)
  );

  assign addr = addr_q;

endmodule

// File: rtl/lbc_addr_counter_chk.sv
module lbc_addr_counter_chk #(
  parameter int ADDR_W = 16,
  parameter int EXP_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              step_en,
  input logic              reload_n,
  input logic              flag_clr_n,
  input logic              dir_down,
  input logic              mode_load,
  input logic [ADDR_W-1:0] reload_val,
  input logic [EXP_W-1:0]  exp_id,
  input logic [ADDR_W-1:0] addr,
  input logic              bank_hit,
  input logic              wrap_flag
);

  localparam int TOP_LSB = ADDR_W - EXP_W;

  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= 1'b1;

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    past_ok && rst |=> addr == '0 && !wrap_flag);

  a_r2_count_up: assert property (@(posedge clk) disable iff (rst)
    past_ok && reload_n && step_en && !dir_down |=> addr == $past(addr) + ADDR_W'(1));

  a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
    past_ok && reload_n && step_en && dir_down |=> addr == $past(addr) - ADDR_W'(1));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    past_ok && reload_n && !step_en |=> $stable(addr));

  a_r5_load: assert property (@(posedge clk) disable iff (rst)
    past_ok && !reload_n && mode_load |=> addr == $past(reload_val));

  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    past_ok && !reload_n && !mode_load |=> addr == ($past(dir_down) ? {ADDR_W{1'b1}} : {ADDR_W{1'b0}}));

  // R7 and R9: a downward wrap sets the flag even when a clear is requested
  a_r7_wrap_sets: assert property (@(posedge clk) disable iff (rst)
    past_ok && reload_n && step_en && dir_down && addr == '0 |=> wrap_flag);

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    past_ok && wrap_flag && flag_clr_n |=> wrap_flag);

  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    past_ok && !flag_clr_n && !(reload_n && step_en && dir_down && addr == '0) |=> !wrap_flag);

  a_r10_bank: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) |-> bank_hit == (addr[ADDR_W-1:TOP_LSB] == $past(exp_id)));

endmodule

bind lbc_addr_counter lbc_addr_counter_chk #(.ADDR_W(ADDR_W), .EXP_W(EXP_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .step_en    (step_en),
  .reload_n   (reload_n),
  .flag_clr_n (flag_clr_n),
  .dir_down   (dir_down),
  .mode_load  (mode_load),
  .reload_val (reload_val),
  .exp_id     (exp_id),
  .addr       (addr),
  .bank_hit   (bank_hit),
  .wrap_flag  (wrap_flag)
);

// File: tb/lbc_addr_counter_test.sv
module lbc_addr_counter_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_en = 1'b0;
  logic        reload_n = 1'b1;
  logic        flag_clr_n = 1'b1;
  logic        dir_down = 1'b0;
  logic        mode_load = 1'b0;
  logic [15:0] reload_val = '0;
  logic [2:0]  exp_id = '0;
  logic [15:0] addr;
  logic        bank_hit;
  logic        wrap_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_addr;
  logic        m_flag;
  logic [2:0]  m_eid;

  always #2 clk = ~clk;

  lbc_addr_counter uut (
    .clk(clk), .rst(rst), .step_en(step_en), .reload_n(reload_n),
    .flag_clr_n(flag_clr_n), .dir_down(dir_down), .mode_load(mode_load),
    .reload_val(reload_val), .exp_id(exp_id), .addr(addr),
    .bank_hit(bank_hit), .wrap_flag(wrap_flag)
  );

  function automatic logic [15:0] ref_next(logic [15:0] a, logic en, logic rl_n,
                                           logic dn, logic md, logic [15:0] v);
    if (!rl_n)   return md ? v : (dn ? 16'hFFFF : 16'h0000);
    else if (en) return dn ? a - 16'd1 : a + 16'd1;
    else         return a;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, "addr", 32'(addr), 32'(m_addr));
    chk(req, "wrap_flag", 32'(wrap_flag), 32'(m_flag));
    chk(req, "bank_hit", 32'(bank_hit), 32'(m_addr[15:13] == m_eid));
  endtask

  // One cycle: drive at negedge, model advances, compare at the next negedge.
  task automatic cyc(logic en, logic rl_n, logic fc_n, logic dn, logic md,
                     logic [15:0] v, logic [2:0] eid);
    logic set;
    step_en = en; reload_n = rl_n; flag_clr_n = fc_n;
    dir_down = dn; mode_load = md; reload_val = v; exp_id = eid;
    set = rl_n && en && dn && (m_addr == 16'h0000);
    m_addr = ref_next(m_addr, en, rl_n, dn, md, v);
    m_flag = set ? 1'b1 : (!fc_n ? 1'b0 : m_flag);
    m_eid  = eid;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] snap;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_addr = '0; m_flag = 1'b0; m_eid = 3'b000;
    // R1: reset state
    chk_all("R1");

    // R2: five up steps
    repeat (5) cyc(1, 1, 1, 0, 0, 16'h0, 3'b000);
    chk("R2", "addr", 32'(addr), 32'h5);
    // R4: hold with step disabled
    repeat (3) cyc(0, 1, 1, 0, 1, 16'hABCD, 3'b000);
    chk("R4", "addr", 32'(addr), 32'h5);
    // R5: load wins over an enabled step
    cyc(1, 0, 1, 0, 1, 16'hFFFE, 3'b000);
    chk("R5", "addr", 32'(addr), 32'hFFFE);
    cyc(1, 1, 1, 0, 0, 16'h0, 3'b000);
    cyc(1, 1, 1, 0, 0, 16'h0, 3'b000);
    chk("R2", "up wrap addr", 32'(addr), 32'h0);
    chk("R8", "up wrap no flag", 32'(wrap_flag), 32'h0);
    // R6: clear after a direction change gives all ones, reload_val ignored
    cyc(0, 0, 1, 1, 0, 16'h1234, 3'b111);
    chk("R6", "clear down", 32'(addr), 32'hFFFF);
    cyc(1, 0, 1, 0, 0, 16'h1234, 3'b111);
    chk("R6", "clear up", 32'(addr), 32'h0);
    // R3 and R7: down through zero
    cyc(0, 0, 1, 1, 1, 16'h0002, 3'b000);
    cyc(1, 1, 1, 1, 0, 16'h0, 3'b000);
    cyc(1, 1, 1, 1, 0, 16'h0, 3'b000);
    chk("R3", "addr", 32'(addr), 32'h0);
    chk("R7", "no early flag", 32'(wrap_flag), 32'h0);
    cyc(1, 1, 1, 1, 0, 16'h0, 3'b111);
    chk("R3", "down wrap addr", 32'(addr), 32'hFFFF);
    chk("R7", "flag set", 32'(wrap_flag), 32'h1);
    chk("R10", "hit on 111", 32'(bank_hit), 32'h1);
    // R8: sticky, then cleared
    repeat (3) cyc(0, 1, 1, 1, 0, 16'h0, 3'b111);
    cyc(1, 1, 1, 0, 0, 16'h0, 3'b000);
    chk("R8", "sticky", 32'(wrap_flag), 32'h1);
    cyc(0, 1, 0, 0, 0, 16'h0, 3'b000);
    chk("R8", "cleared", 32'(wrap_flag), 32'h0);
    // R9: wrap and clear at the same edge
    cyc(0, 0, 1, 1, 1, 16'h0000, 3'b000);
    cyc(1, 1, 0, 1, 0, 16'h0, 3'b000);
    chk("R9", "set wins", 32'(wrap_flag), 32'h1);
    // R10: mismatch keeps counting
    cyc(0, 0, 1, 0, 1, 16'h4000, 3'b000);
    chk("R10", "mismatch", 32'(bank_hit), 32'h0);
    snap = addr;
    cyc(1, 1, 1, 0, 0, 16'h0, 3'b000);
    chk("R10", "counts while mismatched", 32'(addr), 32'(snap + 16'd1));
    cyc(0, 0, 1, 1, 1, 16'h2000, 3'b001);
    chk("R10", "match 001", 32'(bank_hit), 32'h1);
    cyc(1, 1, 1, 1, 0, 16'h0, 3'b001);
    chk("R10", "leave bank", 32'(bank_hit), 32'h0);
    chk_all("R10");

    // Random mix, all requirements R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 4000; i++) begin
      logic        en, rl_n, fc_n, dn, md;
      logic [15:0] v;
      logic [2:0]  eid;
      en   = ($urandom % 4) != 0;
      rl_n = ($urandom % 16) != 0;
      fc_n = ($urandom % 8) != 0;
      dn   = (($urandom % 32) == 0) ? ~dir_down : dir_down;
      md   = $urandom % 2;
      v    = (($urandom % 2) != 0) ? 16'($urandom % 4) : 16'($urandom);
      eid  = (($urandom % 64) == 0) ? 3'($urandom) : exp_id;
      cyc(en, rl_n, fc_n, dn, md, v, eid);
      chk_all("R2/R3/R5/R6/R7/R8/R9/R10 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule